// File: doc/BRIEF.md
# Serial register-write frame decoder

This block sits behind a byte-level asynchronous serial receiver and turns a stream of received bytes into register writes. A write is carried by a fixed three-byte frame made of a start flag (0xFF), an address byte and a value byte. The block updates one of seven configuration registers that drive the rest of a time-to-digital converter. It then answers each complete frame with a two-byte reply for a serial transmitter.

The value 0xFF is reserved. Whenever it arrives, the frame restarts, whatever slot the decoder expected to fill. Bytes that arrive outside a frame are dropped without a reply. If the address is in range, the reply is an acknowledge byte. If it is not, the reply is a reject byte and no register changes. In both cases a carriage return follows. The bit-level serial line itself (9600 baud, 8 data bits, one start bit, one stop bit, no parity) belongs to the receiver and transmitter outside this block.

Top module: `cfg_frame_decoder`

## Requirements
- R1: After reset, all registers read zero except the ASIC setup register (address 2), which reads 0x08 so that its power-down bit 3 is set. No reply is pending and no write strobe is active.
- R2: A frame 0xFF, A, V with A in 0..6 writes V into register A. Only the low bits of V that fit the register are kept. Widths are: address 0 time-out 8 bits, 1 mode 5 bits, 2 ASIC setup 6 bits, 3 clock select 3 bits, 4 test 8 bits, 5 X offset 8 bits, 6 Y offset 8 bits.
- R3: A byte other than 0xFF that arrives while no frame is open is discarded. It causes no write and no reply.
- R4: 0xFF received in the address or value slot opens a new frame. The next two non-0xFF bytes are then taken as address and value.
- R5: A frame with an address in 0..6 is answered with 0x3D ('='), then 0x0D.
- R6: A frame with an address byte in 7..0xFE is answered with 0x3F ('?'), then 0x0D, and leaves every register unchanged.
- R7: A reply byte is held on tx_data_o with tx_valid_o high until tx_ready_i is sampled high. The carriage return is presented only after the first byte is accepted, and only 0x3D, 0x3F or 0x0D is ever presented.
- R8: wr_strobe_o is high for exactly one cycle, in the cycle after the clock edge that accepts the value byte. wr_addr_o carries the written address in that cycle, and the register output already shows the new value. A register never changes in any other cycle.
- R9: A frame that completes while a reply is still pending still writes its register, but its own reply is dropped.
- R10: rx_data_i is ignored in any cycle where rx_valid_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received byte |
| rx_valid_i | input | 1 | rx_data_i holds a new byte this cycle |
| tx_ready_i | input | 1 | Transmitter accepts tx_data_o this cycle |
| tx_data_o | output | 8 | Reply byte |
| tx_valid_o | output | 1 | Reply byte available |
| wr_strobe_o | output | 1 | One-cycle register write pulse |
| wr_addr_o | output | 3 | Address of the register just written |
| timeout_o | output | 8 | Gate time-out register (address 0) |
| mode_o | output | 5 | Operating mode register (address 1) |
| asic_cfg_o | output | 6 | ASIC setup register (address 2) |
| clk_sel_o | output | 3 | Resolution / clock select register (address 3) |
| test_o | output | 8 | Test register (address 4) |
| offset_x_o | output | 8 | X offset register (address 5) |
| offset_y_o | output | 8 | Y offset register (address 6) |

## Verification
On every cycle, the assertions check that a held reply byte stays stable, that only the three legal reply codes appear, and that a carriage return always follows an accepted first byte. They also check that the write strobe is a single-cycle pulse with a legal address, and that no register moves without that strobe. Some behaviours depend on the byte sequence and on the values written, so only the bench scenarios can show them. These are the masking of each register to its width, the resynchronisation on a stray 0xFF, the discarding of bytes outside a frame and of bytes without a valid, the reject path for high addresses, and the reply dropped when a frame completes with a reply still pending.

// File: rtl/cfg_frame_pkg.sv
package cfg_frame_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 7;
  localparam int ADDR_W   = $clog2(NUM_REGS);

  localparam logic [BYTE_W-1:0] SOF_BYTE = 8'hFF;
  localparam logic [BYTE_W-1:0] ACK_OK   = 8'h3D;
  localparam logic [BYTE_W-1:0] ACK_BAD  = 8'h3F;
  localparam logic [BYTE_W-1:0] ACK_END  = 8'h0D;

  typedef enum logic [1:0] {P_HUNT, P_ADDR, P_DATA} parse_st_e;
  typedef enum logic [1:0] {Q_IDLE, Q_FIRST, Q_LAST} ackq_st_e;

  function automatic int reg_width(int idx);
    case (idx)
      1:       return 5;
      2:       return 6;
      3:       return 3;
      default: return 8;
    endcase
  endfunction

  // ASIC setup starts powered down (bit 3)
  function automatic logic [BYTE_W-1:0] reg_reset(int idx);
    return (idx == 2) ? 8'h08 : 8'h00;
  endfunction
endpackage

// File: rtl/cfg_frame_parser.sv
module cfg_frame_parser
  import cfg_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] rx_data_i,
  input  logic              rx_valid_i,
  output logic              done_o,
  output logic              in_range_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  parse_st_e         st_q, st_d;
  logic [BYTE_W-1:0] addr_q;
  logic              is_sof, take;

  always_comb begin
    is_sof     = rx_valid_i && (rx_data_i == SOF_BYTE);
    take       = rx_valid_i && (rx_data_i != SOF_BYTE);
    done_o     = take && (st_q == P_DATA);
    in_range_o = addr_q < BYTE_W'(NUM_REGS);
    wr_en_o    = done_o && in_range_o;
    wr_addr_o  = addr_q[ADDR_W-1:0];
    wr_data_o  = rx_data_i;
  end

  always_comb begin
    st_d = st_q;
    if (is_sof) st_d = P_ADDR;
    else if (take) begin
      case (st_q)
        P_ADDR:  st_d = P_DATA;
        P_DATA:  st_d = P_HUNT;
        default: st_d = P_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= P_HUNT;
      addr_q <= '0;
    end else begin
      st_q <= st_d;
      if (take && st_q == P_ADDR) addr_q <= rx_data_i;
    end
  end
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_frame_pkg::*;
(
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [ADDR_W-1:0]              wr_addr_i,
  input  logic [BYTE_W-1:0]              wr_data_i,
  output logic                           strobe_o,
  output logic [ADDR_W-1:0]              strobe_addr_o,
  output logic [NUM_REGS-1:0][BYTE_W-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam int              W   = reg_width(i);
    localparam logic [BYTE_W-1:0] RST = reg_reset(i);
    logic [W-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 q <= RST[W-1:0];
      else if (wr_en_i && wr_addr_i == ADDR_W'(i)) q <= wr_data_i[W-1:0];
    end
    assign regs_o[i] = BYTE_W'(q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_o      <= 1'b0;
      strobe_addr_o <= '0;
    end else begin
      strobe_o <= wr_en_i;
      if (wr_en_i) strobe_addr_o <= wr_addr_i;
    end
  end
endmodule

// File: rtl/cfg_ack_queue.sv
module cfg_ack_queue
  import cfg_frame_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              ok_i,
  input  logic              tx_ready_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o
);
  ackq_st_e st_q;
  logic     ok_q;

  assign tx_valid_o = (st_q != Q_IDLE);
  assign tx_data_o  = (st_q == Q_LAST) ? ACK_END : (ok_q ? ACK_OK : ACK_BAD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= Q_IDLE;
      ok_q <= 1'b0;
    end else begin
      case (st_q)
        Q_IDLE:  if (load_i) begin st_q <= Q_FIRST; ok_q <= ok_i; end
        Q_FIRST: if (tx_ready_i) st_q <= Q_LAST;
        Q_LAST:  if (tx_ready_i) st_q <= Q_IDLE;
        default: st_q <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_frame_decoder.sv
module cfg_frame_decoder
  import cfg_frame_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] rx_data_i,
  input  logic       rx_valid_i,
  input  logic       tx_ready_i,
  output logic [7:0] tx_data_o,
  output logic       tx_valid_o,
  output logic       wr_strobe_o,
  output logic [2:0] wr_addr_o,
  output logic [7:0] timeout_o,
  output logic [4:0] mode_o,
  output logic [5:0] asic_cfg_o,
  output logic [2:0] clk_sel_o,
  output logic [7:0] test_o,
  output logic [7:0] offset_x_o,
  output logic [7:0] offset_y_o
);
  logic                            done, in_range, wr_en;
  logic [ADDR_W-1:0]               wr_addr;
  logic [BYTE_W-1:0]               wr_data;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

  cfg_frame_parser u_parser (
    .clk_i, .rst_ni, .rx_data_i, .rx_valid_i,
    .done_o(done), .in_range_o(in_range), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  cfg_reg_bank u_bank (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .strobe_o(wr_strobe_o), .strobe_addr_o(wr_addr_o), .regs_o(regs)
  );

  cfg_ack_queue u_ackq (
    .clk_i, .rst_ni, .load_i(done), .ok_i(in_range), .tx_ready_i,
    .tx_data_o, .tx_valid_o
  );

  assign timeout_o  = regs[0];
  assign mode_o     = regs[1][4:0];
  assign asic_cfg_o = regs[2][5:0];
  assign clk_sel_o  = regs[3][2:0];
  assign test_o     = regs[4];
  assign offset_x_o = regs[5];
  assign offset_y_o = regs[6];
endmodule

// File: rtl/cfg_frame_decoder_chk.sv
module cfg_frame_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_ready_i,
  input logic [7:0] tx_data_o,
  input logic       tx_valid_o,
  input logic       wr_strobe_o,
  input logic [2:0] wr_addr_o,
  input logic [7:0] timeout_o,
  input logic [4:0] mode_o,
  input logic [5:0] asic_cfg_o,
  input logic [2:0] clk_sel_o,
  input logic [7:0] test_o,
  input logic [7:0] offset_x_o,
  input logic [7:0] offset_y_o
);
  logic [45:0] regs_all;
  assign regs_all = {timeout_o, mode_o, asic_cfg_o, clk_sel_o, test_o, offset_x_o, offset_y_o};

  AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o)); // R7
  AST_TX_CODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_data_o == 8'h3D || tx_data_o == 8'h3F || tx_data_o == 8'h0D)); // R7
  AST_CR_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_data_o != 8'h0D |=> tx_valid_o && tx_data_o == 8'h0D); // R5
  AST_STROBE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |=> !wr_strobe_o); // R8
  AST_STROBE_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o |-> wr_addr_o < 3'd7); // R6
  AST_REGS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_strobe_o |-> $stable(regs_all)); // R8
  AST_STROBE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_strobe_o && !$past(tx_valid_o) |-> tx_valid_o && tx_data_o == 8'h3D); // R5
endmodule

bind cfg_frame_decoder cfg_frame_decoder_chk u_chk (.*);

// File: tb/tb_cfg_frame_decoder.sv
module tb_cfg_frame_decoder;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       rx_valid_i = 1'b0, tx_ready_i = 1'b1;
  logic [7:0] tx_data_o;
  logic       tx_valid_o, wr_strobe_o;
  logic [2:0] wr_addr_o;
  logic [7:0] timeout_o, test_o, offset_x_o, offset_y_o;
  logic [4:0] mode_o;
  logic [5:0] asic_cfg_o;
  logic [2:0] clk_sel_o;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfg_frame_decoder dut (.*);

  // {addr, value, expected register, expected first reply byte}
  localparam logic [31:0] VEC [12] = '{
    {8'h00, 8'h12, 8'h12, 8'h3D}, {8'h01, 8'h1F, 8'h1F, 8'h3D},
    {8'h01, 8'hE3, 8'h03, 8'h3D}, {8'h02, 8'h35, 8'h35, 8'h3D},
    {8'h02, 8'hC5, 8'h05, 8'h3D}, {8'h03, 8'h07, 8'h07, 8'h3D},
    {8'h03, 8'h0E, 8'h06, 8'h3D}, {8'h04, 8'hA5, 8'hA5, 8'h3D},
    {8'h05, 8'h68, 8'h68, 8'h3D}, {8'h06, 8'h7F, 8'h7F, 8'h3D},
    {8'h07, 8'h11, 8'h00, 8'h3F}, {8'hFE, 8'h22, 8'h00, 8'h3F}
  };

  function automatic logic [45:0] snap();
    return {timeout_o, mode_o, asic_cfg_o, clk_sel_o, test_o, offset_x_o, offset_y_o};
  endfunction

  function automatic logic [7:0] reg_of(input logic [7:0] a);
    case (a)
      8'd0: return timeout_o;
      8'd1: return {3'b0, mode_o};
      8'd2: return {2'b0, asic_cfg_o};
      8'd3: return {5'b0, clk_sel_o};
      8'd4: return test_o;
      8'd5: return offset_x_o;
      default: return offset_y_o;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    rx_data_i = b; rx_valid_i = 1'b1;
    @(negedge clk_i);
    rx_valid_i = 1'b0; rx_data_i = 8'h00;
  endtask

  task automatic frame(input logic [7:0] a, input logic [7:0] v);
    send(8'hFF); send(a); send(v);
  endtask

  // called at the negedge right after the value byte, tx_ready_i high
  task automatic reply(input string tag, input logic [7:0] first);
    chk({tag, " reply first"}, {tx_valid_o, tx_data_o}, {1'b1, first});
    @(negedge clk_i);
    chk({tag, " reply CR"}, {tx_valid_o, tx_data_o}, {1'b1, 8'h0D});
    @(negedge clk_i);
    chk({tag, " reply done"}, tx_valid_o, 1'b0);
  endtask

  initial begin
    logic [45:0] s;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 regs", snap(), {8'h00, 5'h00, 6'h08, 3'h0, 8'h00, 8'h00, 8'h00});
    chk("R1 tx_valid", tx_valid_o, 1'b0);
    chk("R1 strobe", wr_strobe_o, 1'b0);

    // R3 stray bytes before any start flag
    s = snap();
    send(8'h05); send(8'h22); send(8'h01);
    chk("R3 no reply", tx_valid_o, 1'b0);
    chk("R3 no strobe", wr_strobe_o, 1'b0);
    chk("R3 regs", snap(), s);
    @(negedge clk_i);
    chk("R3 regs later", snap(), s);

    // R10 0xFF on data lines without valid is not a start flag
    rx_data_i = 8'hFF; @(negedge clk_i); rx_data_i = 8'h00;
    send(8'h03); send(8'h05);
    @(negedge clk_i);
    chk("R10 no reply", tx_valid_o, 1'b0);
    chk("R10 clk_sel", clk_sel_o, 3'h0);

    // R2 R5 R6 R8 vector table
    foreach (VEC[i]) begin
      logic [7:0] a, v, e, k;
      {a, v, e, k} = VEC[i];
      s = snap();
      frame(a, v);
      if (k == 8'h3D) begin
        chk("R8 strobe", {wr_strobe_o, wr_addr_o}, {1'b1, a[2:0]});
        chk("R2 value", reg_of(a), e);
        reply("R5", k);
        chk("R8 strobe gone", wr_strobe_o, 1'b0);
      end else begin
        chk("R6 no strobe", wr_strobe_o, 1'b0);
        chk("R6 regs", snap(), s);
        reply("R6", k);
      end
    end

    // R4 start flag in the address slot
    frame(8'hFF, 8'h05); send(8'h44);
    chk("R4 addr slot", offset_x_o, 8'h44);
    reply("R4", 8'h3D);

    // R4 start flag in the value slot
    s = snap();
    send(8'hFF); send(8'h01); send(8'hFF); send(8'h06);
    chk("R4 no early reply", tx_valid_o, 1'b0);
    send(8'h33);
    chk("R4 value slot", offset_y_o, 8'h33);
    chk("R4 mode kept", mode_o, s[37:33]);
    reply("R4", 8'h3D);

    // R7 R9 reply held while transmitter stalls, second frame's reply dropped
    tx_ready_i = 1'b0;
    frame(8'h00, 8'h21);
    chk("R7 first byte", {tx_valid_o, tx_data_o}, {1'b1, 8'h3D});
    chk("R2 timeout", timeout_o, 8'h21);
    frame(8'h04, 8'h5A);
    chk("R9 write anyway", test_o, 8'h5A);
    chk("R7 held", {tx_valid_o, tx_data_o}, {1'b1, 8'h3D});
    repeat (2) @(negedge clk_i);
    chk("R7 still held", {tx_valid_o, tx_data_o}, {1'b1, 8'h3D});
    tx_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R7 CR after accept", {tx_valid_o, tx_data_o}, {1'b1, 8'h0D});
    @(negedge clk_i);
    chk("R9 reply dropped", tx_valid_o, 1'b0);
    repeat (2) @(negedge clk_i);
    chk("R9 stays idle", tx_valid_o, 1'b0);

    // R6 out-of-range address with a stalled transmitter
    tx_ready_i = 1'b0;
    s = snap();
    frame(8'h80, 8'h01);
    chk("R6 reject held", {tx_valid_o, tx_data_o}, {1'b1, 8'h3F});
    chk("R6 regs kept", snap(), s);
    tx_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R6 CR", tx_data_o, 8'h0D);
    @(negedge clk_i);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule